// File: doc/BRIEF.md
# DSP Register Load/Store Formatter

This block forms the register-side data for single transfers between memory and a DSP register file. The file holds two 40-bit accumulators, made of a 32-bit body and an 8-bit guard part, and six 32-bit input registers. For one transfer the caller presents a register selector, a transfer size (16-bit word or 32-bit longword), a direction, the data read from memory, and the current contents of the selected register. One clock later the block presents either a one-hot register write enable with the formatted 40-bit write value, or a 32-bit store word for the memory bus.

On a load, a word goes into the upper half of the register and the lower half is cleared. A longword fills both halves. The accumulator guard bits take the sign of the loaded value. Each guard part can also be addressed as a register of its own. On a store, a word comes from the upper half of the source register. A stored guard part is sign-extended to fill the bus. Any selector outside the legal set, including the one that would name the DSP status register, writes nothing and raises an illegal-operand flag. The memory access itself and its timing are handled outside this block.

Top module: `dsp_xfer_fmt`

## Requirements
- R1: Selector codes are 0 X0, 1 X1, 2 Y0, 3 Y1, 4 M0, 5 M1, 6 A0, 7 A1, 8 A0 guard, 9 A1 guard. A legal load asserts exactly the `wr_en` bit whose index equals the selector.
- R2: A word load (`req_long`=0) into X0..M1 writes `mem_rdata[15:0]` to value bits [31:16], zero to bits [15:0] and zero to bits [39:32].
- R3: A word load into A0 or A1 writes `mem_rdata[15:0]` to bits [31:16] and zero to bits [15:0]. Bits [39:32] are all copies of `mem_rdata[15]`.
- R4: A longword load into A0 or A1 writes `mem_rdata[31:0]` to bits [31:0]. Bits [39:32] are all copies of `mem_rdata[31]`.
- R5: A longword load into X0..M1 writes `mem_rdata[31:0]` to bits [31:0] and zero to bits [39:32].
- R6: A load into a guard register (selector 8 or 9), of either size, writes `mem_rdata[7:0]` to bits [39:32] and zero to bits [31:0].
- R7: A word store from X0..A1 outputs `rf_rdata[31:16]` on `st_data[15:0]`, with `st_data[31:16]` all copies of `rf_rdata[31]`.
- R8: A longword store from X0..A1 outputs `rf_rdata[31:0]` on `st_data`.
- R9: A store from a guard register, of either size, outputs `rf_rdata[39:32]` on `st_data[7:0]`, with `st_data[31:8]` all copies of `rf_rdata[39]`.
- R10: A request with a selector of 10..15 (10 is the status register) sets `illegal`, writes no register and leaves `st_valid` low with `st_data` zero.
- R11: A store never asserts any `wr_en` bit, so the lower word and every other bit of the register are left unchanged.
- R12: Outputs are registered. A request appears one cycle later. After reset and after any idle cycle, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request this cycle |
| req_load | input | 1 | 1 = load into register, 0 = store to memory |
| req_long | input | 1 | 1 = longword, 0 = word |
| req_sel | input | 4 | Register selector (codes in R1) |
| mem_rdata | input | 32 | Data read from memory; a word is in [15:0] |
| rf_rdata | input | 40 | Current value of the selected register, guard in [39:32] |
| wr_en | output | 10 | One-hot register write enable, indexed by selector code |
| wr_val | output | 40 | Formatted register write value |
| st_valid | output | 1 | Store data valid |
| st_data | output | 32 | Formatted store data for the memory bus |
| illegal | output | 1 | Illegal register selection flag |

## Verification
Some properties are checked on every cycle: the write enable is one-hot or zero, stores and illegal selections never write, and idle cycles leave the outputs zero. The sign copy into the guard bits on word accumulator loads and the sign extension of guard-part stores are also checked on every cycle. Only the bench's scenarios can show that each selector reaches its own enable bit and that data sits in the correct halves for each size. The same holds for the exact values of the sign fill for positive and negative data. The bench compares every clock against a behavioural model under directed patterns and random traffic.

// File: rtl/dsp_xfer_pkg.sv
package dsp_xfer_pkg;

    localparam int SEL_W = 4;
    localparam int NREG  = 10;

    typedef enum logic [SEL_W-1:0] {
        SEL_X0 = 4'd0,
        SEL_X1 = 4'd1,
        SEL_Y0 = 4'd2,
        SEL_Y1 = 4'd3,
        SEL_M0 = 4'd4,
        SEL_M1 = 4'd5,
        SEL_A0 = 4'd6,
        SEL_A1 = 4'd7,
        SEL_G0 = 4'd8,
        SEL_G1 = 4'd9
    } reg_sel_e;

endpackage

// File: rtl/dsp_sel_decode.sv
module dsp_sel_decode
    import dsp_xfer_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output logic [NREG-1:0]  hit,
    output logic             legal,
    output logic             is_acc,
    output logic             is_guard
);
    // One comparator per register slot
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = (sel == SEL_W'(i));
    end

    assign legal    = |hit;
    assign is_acc   = hit[SEL_A0] | hit[SEL_A1];
    assign is_guard = hit[SEL_G0] | hit[SEL_G1];
endmodule

// File: rtl/dsp_load_fmt.sv
module dsp_load_fmt #(
    parameter int WORD_W  = 16,
    parameter int GUARD_W = 8
) (
    input  logic                        is_long,
    input  logic                        is_acc,
    input  logic                        is_guard,
    input  logic [2*WORD_W-1:0]         data,
    output logic [2*WORD_W+GUARD_W-1:0] val
);
    localparam int LONG_W = 2 * WORD_W;

    logic [WORD_W-1:0]  hi_part;
    logic [WORD_W-1:0]  lo_part;
    logic [GUARD_W-1:0] g_part;
    logic               sign_bit;

    always_comb begin
        if (is_long) begin
            hi_part  = data[LONG_W-1:WORD_W];
            lo_part  = data[WORD_W-1:0];
            sign_bit = data[LONG_W-1];
        end else begin
            hi_part  = data[WORD_W-1:0];
            lo_part  = '0;
            sign_bit = data[WORD_W-1];
        end
        g_part = is_acc ? {GUARD_W{sign_bit}} : '0;

        if (is_guard) begin
            val = {data[GUARD_W-1:0], {LONG_W{1'b0}}};
        end else begin
            val = {g_part, hi_part, lo_part};
        end
    end
endmodule

// File: rtl/dsp_store_fmt.sv
module dsp_store_fmt #(
    parameter int WORD_W  = 16,
    parameter int GUARD_W = 8
) (
    input  logic                        is_long,
    input  logic                        is_guard,
    input  logic [2*WORD_W+GUARD_W-1:0] rdata,
    output logic [2*WORD_W-1:0]         st
);
    localparam int LONG_W = 2 * WORD_W;
    localparam int ACC_W  = LONG_W + GUARD_W;

    always_comb begin
        if (is_guard) begin
            st = {{(LONG_W-GUARD_W){rdata[ACC_W-1]}}, rdata[ACC_W-1:LONG_W]};
        end else if (is_long) begin
            st = rdata[LONG_W-1:0];
        end else begin
            st = {{WORD_W{rdata[LONG_W-1]}}, rdata[LONG_W-1:WORD_W]};
        end
    end
endmodule

// File: rtl/dsp_xfer_fmt.sv
module dsp_xfer_fmt
    import dsp_xfer_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int GUARD_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_load,
    input  logic                        req_long,
    input  logic [SEL_W-1:0]            req_sel,
    input  logic [2*WORD_W-1:0]         mem_rdata,
    input  logic [2*WORD_W+GUARD_W-1:0] rf_rdata,
    output logic [NREG-1:0]             wr_en,
    output logic [2*WORD_W+GUARD_W-1:0] wr_val,
    output logic                        st_valid,
    output logic [2*WORD_W-1:0]         st_data,
    output logic                        illegal
);
    localparam int LONG_W = 2 * WORD_W;
    localparam int ACC_W  = LONG_W + GUARD_W;

    typedef struct packed {
        logic [NREG-1:0]   wr_en;
        logic [ACC_W-1:0]  wr_val;
        logic              st_valid;
        logic [LONG_W-1:0] st_data;
        logic              illegal;
    } out_t;

    out_t out_d, out_q;

    logic [NREG-1:0]   hit;
    logic              legal, is_acc, is_guard;
    logic [ACC_W-1:0]  ld_val;
    logic [LONG_W-1:0] st_val;

    dsp_sel_decode i_dec (
        .sel      (req_sel),
        .hit      (hit),
        .legal    (legal),
        .is_acc   (is_acc),
        .is_guard (is_guard)
    );

    dsp_load_fmt #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) i_ld (
        .is_long  (req_long),
        .is_acc   (is_acc),
        .is_guard (is_guard),
        .data     (mem_rdata),
        .val      (ld_val)
    );

    dsp_store_fmt #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) i_st (
        .is_long  (req_long),
        .is_guard (is_guard),
        .rdata    (rf_rdata),
        .st       (st_val)
    );

    always_comb begin
        out_d = '0;
        if (req_valid) begin
            if (!legal) begin
                out_d.illegal = 1'b1;
            end else if (req_load) begin
                out_d.wr_en  = hit;
                out_d.wr_val = ld_val;
            end else begin
                out_d.st_valid = 1'b1;
                out_d.st_data  = st_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wr_en    = out_q.wr_en;
    assign wr_val   = out_q.wr_val;
    assign st_valid = out_q.st_valid;
    assign st_data  = out_q.st_data;
    assign illegal  = out_q.illegal;
endmodule

// File: rtl/dsp_xfer_fmt_chk.sv
module dsp_xfer_fmt_chk #(
    parameter int WORD_W  = 16,
    parameter int GUARD_W = 8,
    parameter int NREG    = 10
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_load,
    input logic                        req_long,
    input logic [3:0]                  req_sel,
    input logic [NREG-1:0]             wr_en,
    input logic [2*WORD_W+GUARD_W-1:0] wr_val,
    input logic                        st_valid,
    input logic [2*WORD_W-1:0]         st_data,
    input logic                        illegal
);
    localparam int LONG_W = 2 * WORD_W;
    localparam int ACC_W  = LONG_W + GUARD_W;

    assert_enable_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    assert_word_acc_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid && req_load && !req_long && (req_sel == 4'd6 || req_sel == 4'd7)))
        |-> (wr_val[ACC_W-1:LONG_W] == {GUARD_W{wr_val[LONG_W-1]}}
             && wr_val[WORD_W-1:0] == '0));

    assert_guard_store_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid && !req_load && (req_sel == 4'd8 || req_sel == 4'd9)))
        |-> (st_valid && st_data[LONG_W-1:GUARD_W] == {(LONG_W-GUARD_W){st_data[GUARD_W-1]}}));

    assert_illegal_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (wr_en == '0 && !st_valid && st_data == '0));

    assert_illegal_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_sel > 4'd9) |-> illegal);

    assert_store_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_load) |-> (wr_en == '0));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!req_valid) |-> (wr_en == '0 && !st_valid && !illegal));

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_valid && (wr_en != '0)));
endmodule

bind dsp_xfer_fmt dsp_xfer_fmt_chk #(
    .WORD_W (WORD_W),
    .GUARD_W(GUARD_W),
    .NREG   (dsp_xfer_pkg::NREG)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_load  (req_load),
    .req_long  (req_long),
    .req_sel   (req_sel),
    .wr_en     (wr_en),
    .wr_val    (wr_val),
    .st_valid  (st_valid),
    .st_data   (st_data),
    .illegal   (illegal)
);

// File: tb/test_dsp_xfer_fmt.sv
module test_dsp_xfer_fmt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_load = 1'b0;
    logic        req_long = 1'b0;
    logic [3:0]  req_sel = '0;
    logic [31:0] mem_rdata = '0;
    logic [39:0] rf_rdata = '0;
    logic [9:0]  wr_en;
    logic [39:0] wr_val;
    logic        st_valid;
    logic [31:0] st_data;
    logic        illegal;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [9:0]  e_en = '0;
    logic [39:0] e_val = '0;
    logic        e_sv = 1'b0;
    logic [31:0] e_sd = '0;
    logic        e_ill = 1'b0;
    string       e_tag = "R12";
    bit          e_store = 1'b0;

    always #4 clk = ~clk;

    dsp_xfer_fmt i_dsp_xfer_fmt (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
        .req_long(req_long), .req_sel(req_sel), .mem_rdata(mem_rdata),
        .rf_rdata(rf_rdata), .wr_en(wr_en), .wr_val(wr_val),
        .st_valid(st_valid), .st_data(st_data), .illegal(illegal)
    );

    // Behavioural reference for one request
    task automatic model(input bit v, input bit ld, input bit lg, input int sel,
                         input logic [31:0] d, input logic [39:0] r);
        logic [7:0]  g;
        logic [15:0] hi, lo;
        bit acc, grd;
        e_en = '0; e_val = '0; e_sv = 0; e_sd = '0; e_ill = 0; e_store = 0;
        acc = (sel == 6 || sel == 7);
        grd = (sel == 8 || sel == 9);
        if (!v) begin
            e_tag = "R12";
        end else if (sel > 9) begin
            e_ill = 1; e_tag = "R10";
        end else if (ld) begin
            e_en = 10'(1 << sel);
            if (grd) begin
                e_val = {d[7:0], 32'd0}; e_tag = "R6";
            end else begin
                if (lg) begin hi = d[31:16]; lo = d[15:0]; end
                else begin hi = d[15:0]; lo = 16'd0; end
                g = (acc && hi[15]) ? 8'hFF : 8'h00;
                e_val = {g, hi, lo};
                e_tag = acc ? (lg ? "R4" : "R3") : (lg ? "R5" : "R2");
            end
        end else begin
            e_sv = 1; e_store = 1;
            if (grd) begin
                e_sd = 32'($signed(r[39:32])); e_tag = "R9";
            end else if (lg) begin
                e_sd = r[31:0]; e_tag = "R8";
            end else begin
                e_sd = 32'($signed(r[31:16])); e_tag = "R7";
            end
        end
    endtask

    task automatic compare();
        n_vec++;
        if (wr_en !== e_en) begin
            n_bad++;
            $display("FAIL %s wr_en act=%h exp=%h", e_store ? "R11" : "R1", wr_en, e_en);
        end else if (wr_val !== e_val || st_valid !== e_sv || st_data !== e_sd || illegal !== e_ill) begin
            n_bad++;
            $display("FAIL %s act val=%h sv=%b sd=%h ill=%b exp val=%h sv=%b sd=%h ill=%b",
                     e_tag, wr_val, st_valid, st_data, illegal, e_val, e_sv, e_sd, e_ill);
        end
    endtask

    task automatic step(input bit v, input bit ld, input bit lg, input int sel,
                        input logic [31:0] d, input logic [39:0] r);
        @(negedge clk);
        compare();
        req_valid = v; req_load = ld; req_long = lg; req_sel = 4'(sel);
        mem_rdata = d; rf_rdata = r;
        model(v, ld, lg, sel, d, r);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state checked at first compare
        step(0, 0, 0, 0, 32'h0, 40'h0);
        // R1/R2/R5: every input register, word and long, both signs
        for (int s = 0; s < 6; s++) begin
            step(1, 1, 0, s, 32'h1234_8765, 40'h0);
            step(1, 1, 1, s, 32'h9ABC_0F0F, 40'h0);
            step(1, 1, 0, s, 32'hFFFF_7001, 40'h0);
        end
        // R3/R4: accumulators, positive and negative
        for (int s = 6; s < 8; s++) begin
            step(1, 1, 0, s, 32'h0000_8001, 40'h0);
            step(1, 1, 0, s, 32'hFFFF_7FFE, 40'h0);
            step(1, 1, 1, s, 32'h8000_0001, 40'h0);
            step(1, 1, 1, s, 32'h7FFF_FFFF, 40'h0);
        end
        // R6: guard registers, both sizes
        step(1, 1, 0, 8, 32'hAAAA_55C3, 40'h0);
        step(1, 1, 1, 9, 32'h1234_5671, 40'h0);
        // R7/R8/R11: stores
        step(1, 0, 0, 0, 32'h0, 40'h12_8000_1234);
        step(1, 0, 0, 6, 32'h0, 40'hFF_7FFF_FFFF);
        step(1, 0, 1, 7, 32'h0, 40'h00_DEAD_BEEF);
        step(1, 0, 1, 3, 32'h0, 40'h55_0102_0304);
        // R9: guard stores
        step(1, 0, 0, 8, 32'h0, 40'h80_0000_0000);
        step(1, 0, 1, 9, 32'h0, 40'h7F_FFFF_FFFF);
        // R10: illegal selectors, load and store
        for (int s = 10; s < 16; s++) begin
            step(1, 1, s[0], s, 32'hFFFF_FFFF, 40'hFF_FFFF_FFFF);
            step(1, 0, s[0], s, 32'hFFFF_FFFF, 40'hFF_FFFF_FFFF);
        end
        // R12: idle between requests
        step(0, 1, 1, 6, 32'hFFFF_FFFF, 40'h0);
        step(1, 1, 1, 6, 32'hFFFF_FFFF, 40'h0);
        step(0, 0, 0, 0, 32'h0, 40'h0);
        // random traffic
        for (int k = 0; k < 400; k++) begin
            step(($urandom % 5) != 0, $urandom % 2, $urandom % 2, int'($urandom % 16),
                 $urandom, {8'($urandom), 32'($urandom)});
        end
        step(0, 0, 0, 0, 32'h0, 40'h0);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule